// File: doc/BRIEF.md
# Keyed-Sequence One-Shot Watchdog Timer

This block is a watchdog that sits on a simple register write bus (address, data, write strobe) next to a processor core. After reset it is idle. Software arms it by writing a two-byte key to one register address. From then on a 14-bit counter advances once for each machine-cycle strobe. Software keeps the system alive by writing the same key again, which sends the count back to zero. Nothing software writes can turn the watchdog off. Only a hardware reset, or the watchdog's own expiry, returns it to the idle state.

If the count reaches its top value, the block raises a high-active reset output for a fixed number of clock cycles. The same event disarms the watchdog and clears its count. While the reset output is high, the key detector is held cleared, so key writes made during the pulse have no effect. The machine-cycle strobe comes from outside the block; clocks on which the strobe is low are ignored.

Where two events meet in the same cycle, the following order applies:
- Expiry wins over a key completion in the same cycle.
- A key completion wins over a strobe in the same cycle, so the count is zero after that edge.

Top module: `wdog_keyed`

## Requirements
- R1: While armed, the 14-bit count advances by one on each clock edge at which `mc_en` is high. It does not change on edges where `mc_en` is low.
- R2: `rst` is synchronous and active high. After `rst` the watchdog is disarmed, `rst_out` is low, and the count stays at zero whatever `mc_en` does.
- R3: The key is two writes to address 0xA6: first data 0x1E, then data 0xE1. The block arms at the clock edge that accepts the 0xE1 write. From that edge the count starts at zero.
- R4: A write of any value other than 0x1E or 0xE1 to 0xA6, made between the two key bytes, cancels the pending first byte. A lone 0xE1 does not arm the block. When already armed, a cancelled key neither restarts nor disarms the watchdog.
- R5: Writes to any address other than 0xA6 leave the key detector unchanged, even when they fall between the two key bytes.
- R6: While armed, a complete key sequence returns the count to zero at the edge that accepts 0xE1.
- R7: When the count holds 0x3FFF, `rst_out` rises at the next clock edge. With `mc_en` high on every cycle, this is 16384 edges after the key-accepting edge.
- R8: `rst_out` stays high for exactly PULSE_LEN clock cycles (default 96).
- R9: Expiry disarms the block and clears the count. No further pulse occurs until a new key is written.
- R10: Asserting `rst` while armed disarms the block, and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle strobe; count advances only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rst_out | output | 1 | High-active reset pulse on expiry |

## Verification
The only observable output is `rst_out`. So any wrong count, arm latch or key state can show up only in the exact edge on which the pulse rises, or in whether it appears at all. Depending on the fault, that can be up to 16384 strobes later. The bench therefore times every expiry to the exact edge, counted from the edge that accepted the key. It also watches a full count window after every sequence that must not arm the block. A detector that stepped on a bad key or a foreign address, or a counter that took a strobe at the key edge, would move the rise by at least one cycle. A latch that survived a reset or an expiry would produce a pulse where none is expected.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdk_key_detect.sv
module wdk_key_detect #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_ok
);
  import wdk_pkg::*;

  key_state_e st;
  logic       hit;

  // a write that targets the key register while the detector is live
  assign hit    = wr_en && (wr_addr == KEY_ADDR) && !clear;
  assign key_ok = hit && (st == KEY_HALF) && (wr_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st <= KEY_IDLE;
    end else if (hit) begin
      st <= (wr_data == KEY_FIRST) ? KEY_HALF : KEY_IDLE;
    end
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             mc_en,
  input  logic             key_ok,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign ovf = armed && (cnt == CNT_MAX);

  // priority: reset/pulse/expiry, then key, then strobe
  always_ff @(posedge clk) begin
    if (rst || hold || ovf) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (key_ok) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed && mc_en) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int LW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [LW-1:0] LAST = LW'(PULSE_LEN - 1);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      left  <= '0;
    end else if (fire && !pulse) begin
      pulse <= 1'b1;
      left  <= LAST;
    end else if (pulse) begin
      if (left == '0) pulse <= 1'b0;
      else            left  <= left - LW'(1);
    end
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 96,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rst_out
);
  logic             key_ok;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  wdk_key_detect #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .clk(clk), .rst(rst), .clear(rst_out),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_ok(key_ok)
  );

  wdk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hold(rst_out), .mc_en(mc_en),
    .key_ok(key_ok), .armed(armed), .cnt(cnt), .ovf(ovf)
  );

  wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(ovf), .pulse(rst_out)
  );
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             mc_en,
  input logic             key_ok,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!rst_out && !armed && cnt == '0)); // R2

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    !armed |-> cnt == '0); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed && mc_en && !key_ok && cnt != CNT_MAX && !rst_out) |=> cnt == $past(cnt) + CNT_W'(1)); // R1

  AST_COUNT_GATED: assert property (@(posedge clk) disable iff (rst)
    (armed && !mc_en && !key_ok && cnt != CNT_MAX && !rst_out) |=> $stable(cnt)); // R1

  AST_KEY_RESTART: assert property (@(posedge clk) disable iff (rst)
    (key_ok && !(armed && cnt == CNT_MAX)) |=> (armed && cnt == '0)); // R6

  AST_EXPIRY_PULSE: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt == CNT_MAX) |=> (rst_out && !armed)); // R7

  AST_PULSE_DISARMED: assert property (@(posedge clk) disable iff (rst)
    rst_out |-> (!armed && !key_ok)); // R9
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mc_en(mc_en), .key_ok(key_ok),
  .armed(armed), .cnt(cnt), .rst_out(rst_out)
);

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
  localparam int EXPIRE = 16384;
  localparam int PLEN   = 96;
  localparam int QUIET  = 16500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mc_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rst_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_keyed i_wdog_keyed (
    .clk(clk), .rst(rst), .mc_en(mc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rst_out(rst_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one write; returns at the negedge after the accepting posedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // called right after the key-accepting edge
  task automatic expect_expiry(input string tag);
    int early = 0;
    int len;
    for (int i = 0; i < EXPIRE - 1; i++) begin
      @(negedge clk);
      if (rst_out) early++;
    end
    check(early == 0 && rst_out == 1'b0, {tag, " no early pulse"}, early, 0);
    @(negedge clk);
    check(rst_out == 1'b1, {tag, " pulse rises on time"}, rst_out, 1);
    len = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!rst_out) break;
      len++;
    end
    check(len == PLEN, "R8 pulse length", len, PLEN);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_out) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(rst_out == 1'b0, "R2 rst_out low after reset", rst_out, 0);
  endtask

  task automatic t_bad_keys_then_arm();
    wr(8'hA6, 8'hE1);                 // lone second byte
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    wr(8'h10, 8'h1E); wr(8'hA6, 8'hE1);
    expect_quiet(QUIET, "R4 bad keys do not arm (R2 no counting)");
    wr(8'hA6, 8'h1E); wr(8'h22, 8'hE1); wr(8'h30, 8'h00); wr(8'hA6, 8'hE1);
    expect_expiry("R3 R5 R7 arm across foreign writes");
    expect_quiet(QUIET, "R9 disarmed after expiry");
  endtask

  task automatic t_service();
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    repeat (5000) @(negedge clk);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00); wr(8'hA6, 8'hE1);  // cancelled key while armed
    repeat (5000) @(negedge clk);
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    expect_expiry("R6 R4 service restarts, bad key ignored");
  endtask

  task automatic t_hw_reset();
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    repeat (1000) @(negedge clk);
    do_reset();
    expect_quiet(QUIET, "R10 hardware reset disarms");
  endtask

  task automatic t_gated();
    int strobes = 0;
    int early = 0;
    bit ph = 1'b0;
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'hE1);
    while (strobes < EXPIRE - 1) begin
      mc_en = ph;
      ph = ~ph;
      @(negedge clk);
      if (mc_en) strobes++;
      if (rst_out) early++;
    end
    check(early == 0 && rst_out == 1'b0, "R1 no pulse before 16383 strobes", early, 0);
    mc_en = 1'b0;
    @(negedge clk);
    check(rst_out == 1'b1, "R1 R7 pulse after 16383rd strobe", rst_out, 1);
    mc_en = 1'b1;
    repeat (PLEN + 4) @(negedge clk);
    check(rst_out == 1'b0, "R8 pulse ended", rst_out, 0);
  endtask

  initial begin
    t_reset_state();
    t_bad_keys_then_arm();
    t_service();
    t_hw_reset();
    t_gated();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL all: watchdog expired, actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule